// File: doc/BRIEF.md
# Remote DMA Data Port

This block lets a host move bytes between one I/O data port and a byte-wide local packet memory. It does this without giving an address on each access. The host first loads a 16-bit current address and a 16-bit remaining count, each as a low byte and a high byte, through a small byte-wide register port. It also loads the first and last-plus-one pages of the receive ring and a word-mode configuration bit. After that, each data-port access moves 1, 2 or 4 bytes at the current address, steps the address and lowers the count. When the count runs out, a DMA-complete status flag is raised.

Memory exists only in two windows: a 32-byte station-address PROM at the bottom of the map and a main packet window from 16384 up to 49151. Accesses whose base address falls outside both windows never reach the memory port, and reads there return all ones. Memory is a single-cycle synchronous RAM with a one-byte data path. The block therefore splits each access into byte cycles and holds `dp_ready` low until the whole transfer is done.

Register map used by the host (4-bit `reg_addr`):
- 0x0 is the command register: bit 0 halt, bit 3 read, bit 4 write.
- 0x1 holds the ring start page and 0x2 the ring stop page. Page p means address p×256.
- 0x3 and 0x4 hold the current address, low byte and high byte. They can be read and written.
- 0x5 and 0x6 hold the remaining count, low byte and high byte.
- 0x7 is the configuration register: bit 0 selects word mode.
- 0x8 is the status register: bit 6 is DMA-complete, and writing 1 to it clears it.

Top module: `rdma_port`

## Requirements
- R1: A data-port access moves 1 byte when configuration bit 0 is clear and 2 bytes when it is set. An access with `dp_long` high moves 4 bytes.
- R2: After each access the current address increases by the transfer size. If the result equals ring stop page × 256, the address reloads ring start page × 256.
- R3: If the remaining count is less than or equal to the transfer size, the count becomes zero and DMA-complete (status bit 6, `dma_done`) is set. Otherwise the count drops by the transfer size.
- R4: A data-port write while the count is zero is ignored. No memory write is issued, and the address, count and status are unchanged.
- R5: A command write with bit 3 or bit 4 set and bit 0 clear, made while the count is zero, sets DMA-complete at once. With bit 0 set it does not.
- R6: Only base addresses 0–31 and 16384–49151 reach memory. Elsewhere writes issue no memory cycle, and reads return 0xFF, 0xFFFF or 0xFFFFFFFF for access widths of 1, 2 and 4 bytes.
- R7: 2- and 4-byte accesses clear address bit 0 for the memory base. They are little-endian: the byte at the lowest address is in `dp_wdata`/`dp_rdata` bits 7:0.
- R8: The current address reads back at registers 0x3 (low byte) and 0x4 (high byte). Status register 0x8 returns DMA-complete in bit 6, and writing 1 to that bit clears it.
- R9: `dp_ready` is a one-cycle pulse. For an N-byte access it comes on the (N+2)th cycle after acceptance, after the last memory byte. For an ignored write it comes on the first cycle. It is never high without `dp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| dp_valid | input | 1 | Data-port access request, held until `dp_ready` |
| dp_write | input | 1 | 1 = write to memory, 0 = read |
| dp_long | input | 1 | 1 = 4-byte access |
| dp_wdata | input | 32 | Write data, little-endian |
| dp_ready | output | 1 | Access complete, one-cycle pulse |
| dp_rdata | output | 32 | Read data, valid with `dp_ready` |
| mem_en | output | 1 | Memory byte cycle enable |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after `mem_en` |
| dma_done | output | 1 | DMA-complete status flag |

## Verification
On every cycle, the assertions check four things:
- `dp_ready` is a single-cycle pulse.
- A step never leaves the address sitting on the ring stop address.
- A zero count cannot change without a register write.
- No memory write is issued while the count is zero, and DMA-complete only rises after a step or a command write.

The bench's scenarios are the only place where these are shown:
- the byte contents and little-endian ordering;
- the all-ones fill outside the windows;
- odd-address word accesses;
- the exact stall length;
- the zero-count command behaviour with and without the halt bit.

// File: rtl/rdma_pkg.sv
// Shared constants and types for the remote DMA data port.
// Assumes a 4-bit register select and an 8-bit register data path.
package rdma_pkg;
    localparam logic [3:0] RA_CMD     = 4'h0;
    localparam logic [3:0] RA_RING_LO = 4'h1;
    localparam logic [3:0] RA_RING_HI = 4'h2;
    localparam logic [3:0] RA_PTR_LO  = 4'h3;
    localparam logic [3:0] RA_PTR_HI  = 4'h4;
    localparam logic [3:0] RA_LEN_LO  = 4'h5;
    localparam logic [3:0] RA_LEN_HI  = 4'h6;
    localparam logic [3:0] RA_CFG     = 4'h7;
    localparam logic [3:0] RA_STAT    = 4'h8;

    localparam int CMD_HALT  = 0;
    localparam int CMD_RD    = 3;
    localparam int CMD_WR    = 4;
    localparam int STAT_DONE = 6;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_FIN   = 2'd2,
        SQ_RESP  = 2'd3
    } sq_state_t;
endpackage

// File: rtl/rdma_window.sv
// Memory window decode: says whether a base address is backed by memory.
// Assumes both windows lie inside the AW-bit address space.
module rdma_window #(
    parameter int AW         = 16,
    parameter int PROM_BYTES = 32,
    parameter int MAIN_LO    = 16384,
    parameter int MAIN_HI    = 49152
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam int PAD = 32 - AW;

    logic [31:0] addr_w;

    // Widen the address and compare it against both windows.
    always_comb begin
        addr_w = {{PAD{1'b0}}, addr};
        hit = (addr_w < 32'(PROM_BYTES)) ||
              ((addr_w >= 32'(MAIN_LO)) && (addr_w < 32'(MAIN_HI)));
    end
endmodule

// File: rtl/rdma_regs.sv
// Host-visible registers: current address, remaining count, ring pages,
// configuration and the DMA-complete flag. Applies one step per finished
// data-port access. A step takes precedence over a register write to the
// same field in the same cycle.
module rdma_regs
    import rdma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          step_en,
    input  logic [2:0]    step_len,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] remain,
    output logic          word_mode,
    output logic          done
);
    localparam int PW = AW - 8;

    logic [PW-1:0] ring_start, ring_stop;
    logic [AW-1:0] start_addr, stop_addr, next_addr, step_w;
    logic          cmd_zero;

    // Derive the ring addresses, the stepped address and the zero-count command.
    always_comb begin
        start_addr = {ring_start, 8'h00};
        stop_addr  = {ring_stop, 8'h00};
        step_w     = AW'(step_len);
        next_addr  = cur_addr + step_w;
        cmd_zero   = reg_wr && (reg_addr == RA_CMD) && !reg_wdata[CMD_HALT] &&
                     (reg_wdata[CMD_RD] || reg_wdata[CMD_WR]) && (remain == '0);
    end

    // Register writes, then the step update, then the status set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            remain     <= '0;
            ring_start <= '0;
            ring_stop  <= '0;
            word_mode  <= 1'b0;
            done       <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    RA_RING_LO: ring_start <= reg_wdata[PW-1:0];
                    RA_RING_HI: ring_stop  <= reg_wdata[PW-1:0];
                    RA_PTR_LO:  cur_addr[7:0]    <= reg_wdata;
                    RA_PTR_HI:  cur_addr[AW-1:8] <= reg_wdata[PW-1:0];
                    RA_LEN_LO:  remain[7:0]      <= reg_wdata;
                    RA_LEN_HI:  remain[AW-1:8]   <= reg_wdata[PW-1:0];
                    RA_CFG:     word_mode  <= reg_wdata[0];
                    RA_STAT:    if (reg_wdata[STAT_DONE]) done <= 1'b0;
                    default: ;
                endcase
            end
            if (step_en) begin
                cur_addr <= (next_addr == stop_addr) ? start_addr : next_addr;
                if (remain <= step_w) begin
                    remain <= '0;
                    done   <= 1'b1;
                end else begin
                    remain <= remain - step_w;
                end
            end
            if (cmd_zero) done <= 1'b1;
        end
    end

    // Read mux for the host register port.
    always_comb begin
        case (reg_addr)
            RA_PTR_LO: reg_rdata = cur_addr[7:0];
            RA_PTR_HI: reg_rdata = 8'(cur_addr[AW-1:8]);
            RA_STAT:   reg_rdata = {1'b0, done, 6'b0};
            default:   reg_rdata = 8'h00;
        endcase
    end

    // A zero count stays zero unless the host rewrites it.
    assert_len_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (remain == '0 && !(reg_wr && (reg_addr == RA_LEN_LO || reg_addr == RA_LEN_HI)))
        |=> remain == '0);

    // A step never leaves the address on the ring stop address.
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !reg_wr && ring_start != ring_stop) |=> cur_addr != stop_addr);

    // DMA-complete only rises after a step or a register write.
    assert_done_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(step_en || reg_wr));
endmodule

// File: rtl/rdma_seq.sv
// Data-port sequencer: accepts an access, splits it into byte cycles on a
// synchronous RAM with one cycle of read latency, and gathers the read bytes
// in little-endian order. Assumes dp_valid and its qualifiers are held until
// dp_ready.
module rdma_seq
    import rdma_pkg::*;
#(
    parameter int AW         = 16,
    parameter int PROM_BYTES = 32,
    parameter int MAIN_LO    = 16384,
    parameter int MAIN_HI    = 49152
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dp_valid,
    input  logic          dp_write,
    input  logic          dp_long,
    input  logic [31:0]   dp_wdata,
    output logic          dp_ready,
    output logic [31:0]   dp_rdata,
    input  logic          word_mode,
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] remain,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          step_en,
    output logic [2:0]    step_len
);
    sq_state_t     state;
    logic [1:0]    idx, rd_idx;
    logic [2:0]    nbytes, len_now;
    logic [AW-1:0] base, base_now;
    logic          hit, hit_now, wr, skipped, skip_now, rd_pend;
    logic [31:0]   wbuf, rbuf, fill;

    // Work out the size, base and fate of the access offered now.
    always_comb begin
        len_now  = dp_long ? 3'd4 : (word_mode ? 3'd2 : 3'd1);
        base_now = (len_now == 3'd1) ? cur_addr : {cur_addr[AW-1:1], 1'b0};
        skip_now = dp_write && (remain == '0);
    end

    rdma_window #(
        .AW(AW), .PROM_BYTES(PROM_BYTES), .MAIN_LO(MAIN_LO), .MAIN_HI(MAIN_HI)
    ) u_window (
        .addr (base_now),
        .hit  (hit_now)
    );

    // State machine: accept, issue byte cycles, drain, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            idx     <= '0;
            nbytes  <= 3'd1;
            base    <= '0;
            hit     <= 1'b0;
            wr      <= 1'b0;
            skipped <= 1'b0;
            wbuf    <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (dp_valid) begin
                    nbytes  <= len_now;
                    base    <= base_now;
                    hit     <= hit_now;
                    wr      <= dp_write;
                    wbuf    <= dp_wdata;
                    idx     <= '0;
                    skipped <= skip_now;
                    state   <= skip_now ? SQ_RESP : SQ_ISSUE;
                end
                SQ_ISSUE: begin
                    idx <= idx + 2'd1;
                    if (idx == 2'(nbytes - 3'd1)) state <= SQ_FIN;
                end
                SQ_FIN:  state <= SQ_RESP;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Capture each read byte one cycle after its memory cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            rd_idx  <= '0;
            rbuf    <= '0;
        end else begin
            rd_pend <= (state == SQ_ISSUE);
            rd_idx  <= idx;
            if (rd_pend) rbuf[{rd_idx, 3'b000} +: 8] <= mem_rdata;
        end
    end

    // Drive the memory port, the response and the register step.
    always_comb begin
        mem_en    = (state == SQ_ISSUE) && hit;
        mem_we    = wr;
        mem_addr  = base + AW'(idx);
        mem_wdata = wbuf[{idx, 3'b000} +: 8];
        dp_ready  = (state == SQ_RESP);
        fill      = hit ? rbuf : 32'hFFFF_FFFF;
        case (nbytes)
            3'd1:    dp_rdata = {24'h0, fill[7:0]};
            3'd2:    dp_rdata = {16'h0, fill[15:0]};
            default: dp_rdata = fill;
        endcase
        step_en   = (state == SQ_RESP) && !skipped;
        step_len  = nbytes;
    end

    // The response lasts exactly one cycle.
    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dp_ready |=> !dp_ready);

    // No memory write is issued while the count is zero.
    assert_no_write_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> remain != '0);

    // A step always moves 1, 2 or 4 bytes.
    assert_step_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> $countones(step_len) == 1);
endmodule

// File: rtl/rdma_port.sv
// Top level of the remote DMA data port: host registers plus the byte
// sequencer in front of a byte-wide synchronous RAM. Bus decode and interrupt
// routing are handled outside this block.
module rdma_port #(
    parameter int AW         = 16,
    parameter int PROM_BYTES = 32,
    parameter int MAIN_LO    = 16384,
    parameter int MAIN_HI    = 49152
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          dp_valid,
    input  logic          dp_write,
    input  logic          dp_long,
    input  logic [31:0]   dp_wdata,
    output logic          dp_ready,
    output logic [31:0]   dp_rdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          dma_done
);
    logic [AW-1:0] cur_addr, remain;
    logic          word_mode, step_en;
    logic [2:0]    step_len;

    rdma_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .step_en   (step_en),
        .step_len  (step_len),
        .cur_addr  (cur_addr),
        .remain    (remain),
        .word_mode (word_mode),
        .done      (dma_done)
    );

    rdma_seq #(
        .AW(AW), .PROM_BYTES(PROM_BYTES), .MAIN_LO(MAIN_LO), .MAIN_HI(MAIN_HI)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dp_valid  (dp_valid),
        .dp_write  (dp_write),
        .dp_long   (dp_long),
        .dp_wdata  (dp_wdata),
        .dp_ready  (dp_ready),
        .dp_rdata  (dp_rdata),
        .word_mode (word_mode),
        .cur_addr  (cur_addr),
        .remain    (remain),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .step_en   (step_en),
        .step_len  (step_len)
    );
endmodule

// File: tb/tb_rdma_port.sv
// Bench for rdma_port: a behavioural register/memory model predicts every
// access; a bench-side RAM serves the memory port and is checked every clock.
module tb_rdma_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        dp_valid = 1'b0, dp_write = 1'b0, dp_long = 1'b0;
    logic [31:0] dp_wdata = 32'h0;
    logic        dp_ready;
    logic [31:0] dp_rdata;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        dma_done;

    int n_chk = 0, n_fail = 0;
    bit allow_mem = 1'b0;
    bit finished = 1'b0;

    // Model state
    logic [7:0] ram [int];
    logic [7:0] mdl [int];
    int m_addr = 0, m_cnt = 0, m_start = 0, m_stop = 0, m_word = 0;
    bit m_done = 1'b0;

    always #2 clk = ~clk;

    rdma_port dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_valid(dp_valid),
        .dp_write(dp_write), .dp_long(dp_long), .dp_wdata(dp_wdata),
        .dp_ready(dp_ready), .dp_rdata(dp_rdata), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .dma_done(dma_done)
    );

    // Bench RAM: one cycle of read latency.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[int'(mem_addr)] = mem_wdata;
            mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
        end
    end

    // Every clock: memory traffic only when the model allows it, ready only with valid.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (mem_en && !allow_mem) begin
                n_fail++;
                $display("FAIL R6/R4 unexpected memory cycle actual=%h expected=no access", mem_addr);
            end
            if (dp_ready && !dp_valid) begin
                n_fail++;
                $display("FAIL R9 ready without request actual=1 expected=0");
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            4'h0: if (!d[0] && (d[3] || d[4]) && m_cnt == 0) m_done = 1'b1;
            4'h1: m_start = int'(d) << 8;
            4'h2: m_stop = int'(d) << 8;
            4'h3: m_addr = (m_addr & 32'hFF00) | int'(d);
            4'h4: m_addr = (m_addr & 32'h00FF) | (int'(d) << 8);
            4'h5: m_cnt = (m_cnt & 32'hFF00) | int'(d);
            4'h6: m_cnt = (m_cnt & 32'h00FF) | (int'(d) << 8);
            4'h7: m_word = int'(d[0]);
            4'h8: if (d[6]) m_done = 1'b0;
            default: ;
        endcase
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_ptr(input int a, input int c);
        reg_write(4'h3, 8'(a)); reg_write(4'h4, 8'(a >> 8));
        reg_write(4'h5, 8'(c)); reg_write(4'h6, 8'(c >> 8));
    endtask

    // Compare the address readback, status and done port with the model.
    task automatic check_state(input string req);
        logic [7:0] lo, hi, st;
        reg_read(4'h3, lo); reg_read(4'h4, hi); reg_read(4'h8, st);
        check({req, " addr"}, {16'h0, hi, lo}, 32'(m_addr));
        check({req, " status"}, {24'h0, st}, {24'h0, 1'b0, m_done, 6'b0});
        check({req, " dma_done"}, {31'h0, dma_done}, {31'h0, m_done});
    endtask

    function automatic bit in_win(input int a);
        return (a < 32) || (a >= 16384 && a < 49152);
    endfunction

    // One data-port access with full prediction.
    task automatic access(input bit w, input bit lng, input logic [31:0] wd, input string req);
        int n, base, iters, exp_iters, na;
        bit win, skip;
        logic [31:0] exp_rd, got;
        n = lng ? 4 : (m_word != 0 ? 2 : 1);
        base = (n == 1) ? m_addr : (m_addr & 32'hFFFE);
        win = in_win(base);
        skip = w && (m_cnt == 0);
        exp_rd = 32'h0;
        for (int i = 0; i < n; i++) begin
            if (win) begin
                if (w && !skip) mdl[base + i] = wd[8*i +: 8];
                exp_rd[8*i +: 8] = mdl.exists(base + i) ? mdl[base + i] : 8'h00;
            end else begin
                exp_rd[8*i +: 8] = 8'hFF;
            end
        end
        exp_iters = skip ? 1 : n + 2;
        @(negedge clk);
        allow_mem = win && !skip;
        dp_valid = 1'b1; dp_write = w; dp_long = lng; dp_wdata = wd;
        iters = 0;
        got = 32'h0;
        while (1) begin
            @(negedge clk);
            iters++;
            if (dp_ready) begin got = dp_rdata; break; end
            if (iters > 20) break;
        end
        @(negedge clk);
        dp_valid = 1'b0;
        allow_mem = 1'b0;
        check({req, " R9 latency"}, 32'(iters), 32'(exp_iters));
        if (!w) check({req, " R7 read data"}, got, exp_rd);
        if (!skip) begin
            na = (m_addr + n) & 32'hFFFF;
            m_addr = (na == m_stop) ? m_start : na;
            if (m_cnt <= n) begin m_cnt = 0; m_done = 1'b1; end
            else m_cnt = m_cnt - n;
        end
    endtask

    task automatic check_ram(input int a, input string req);
        logic [7:0] act, exp;
        act = ram.exists(a) ? ram[a] : 8'h00;
        exp = mdl.exists(a) ? mdl[a] : 8'h00;
        check(req, {24'h0, act}, {24'h0, exp});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // Reset state (R8)
        check_state("R8 reset");
        check("R9 reset ready", {31'h0, dp_ready}, 32'h0);

        // Ring 0x4000..0x8000, byte mode, three byte writes (R1 R2 R3)
        reg_write(4'h1, 8'h40); reg_write(4'h2, 8'h80); reg_write(4'h7, 8'h00);
        set_ptr(16'h4000, 3);
        access(1, 0, 32'h11, "R1 byte wr0");
        access(1, 0, 32'h22, "R1 byte wr1");
        access(1, 0, 32'h33, "R1 byte wr2");
        check_ram(16'h4000, "R1 ram 4000"); check_ram(16'h4002, "R1 ram 4002");
        check_state("R3 count exhausted");

        // Write with zero count is ignored (R4)
        access(1, 0, 32'h99, "R4 skipped write");
        check_ram(16'h4003, "R4 ram untouched");
        check_state("R4 state unchanged");

        // Status clear (R8)
        reg_write(4'h8, 8'h40);
        check_state("R8 cleared");

        // Zero-count commands (R5)
        reg_write(4'h0, 8'h08); check_state("R5 read cmd");
        reg_write(4'h8, 8'h40);
        reg_write(4'h0, 8'h09); check_state("R5 halted cmd");
        reg_write(4'h0, 8'h10); check_state("R5 write cmd");
        reg_write(4'h8, 8'h40);

        // Word mode at an odd address (R1 R7)
        reg_write(4'h7, 8'h01);
        set_ptr(16'h4001, 4);
        access(1, 0, 32'hBEEF, "R7 word wr odd");
        check_ram(16'h4000, "R7 ram lo"); check_ram(16'h4001, "R7 ram hi");
        check_state("R2 word step");
        access(0, 0, 32'h0, "R7 word rd odd");
        check_state("R3 word done");
        reg_write(4'h8, 8'h40);

        // Longword write and read back (R1 R7)
        set_ptr(16'h4010, 8);
        access(1, 1, 32'h4433_2211, "R1 long wr");
        check_state("R3 long partial");
        set_ptr(16'h4010, 4);
        access(0, 1, 32'h0, "R7 long rd");
        check_state("R3 long done");
        reg_write(4'h8, 8'h40);

        // Ring wrap (R2)
        set_ptr(16'h7FFE, 10);
        access(1, 0, 32'hA55A, "R2 wrap wr");
        check_ram(16'h7FFF, "R2 ram 7fff");
        check_state("R2 wrapped");

        // Outside both windows (R6)
        reg_write(4'h7, 8'h00);
        set_ptr(16'h0100, 4);
        access(0, 0, 32'h0, "R6 byte rd");
        access(1, 0, 32'h12, "R6 byte wr");
        reg_write(4'h7, 8'h01);
        access(0, 0, 32'h0, "R6 word rd");
        access(0, 1, 32'h0, "R6 long rd");
        check_state("R6 after outside");
        reg_write(4'h8, 8'h40);

        // PROM window (R6)
        set_ptr(16'h001E, 2);
        access(1, 0, 32'hCAFE, "R6 prom wr");
        set_ptr(16'h001E, 2);
        access(0, 0, 32'h0, "R6 prom rd");
        reg_write(4'h8, 8'h40);

        // Count larger than size (R3)
        reg_write(4'h7, 8'h00);
        set_ptr(16'h4100, 5);
        for (int k = 0; k < 5; k++) begin
            access(0, 0, 32'h0, "R3 count walk");
            check_state("R3 count walk");
        end

        finish_run();
    end
endmodule